// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates virtual addresses to physical addresses using an inverted page table. The table holds one entry for each physical page frame, not one for each virtual page. A fixed hash folds the virtual page number into a table index. The entry at that index holds three things: a virtual-page tag, a frame number and a resident flag.

A lookup compares the stored tag with the whole requested virtual page number and returns one of three results. A hit gives the frame number joined to the untouched page offset. A miss means the full page table must be consulted elsewhere. A page fault means the tag matched but the page is not resident. A separate write port fills or invalidates entries. Fetching from the backing table, collision chaining and replacement belong to the surrounding logic; this block only reports the outcome.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `rsp_valid` is low and every table entry holds tag 0 with the resident flag clear, so a lookup of page number 0 reports a page fault and a lookup of any other page number reports a miss.
- R2: The table index is bits [7:0] of the 20-bit virtual page number (`req_vaddr[31:12]`) XORed with bits [15:8]; page-number bits [19:16] do not affect the index.
- R3: When the stored tag equals the full 20-bit page number and the resident flag is set, the status is hit (2'b00) and `rsp_paddr` is {stored frame, offset}.
- R4: When the stored tag equals the page number and the resident flag is clear, the status is page fault (2'b10).
- R5: When the stored tag differs from the page number, the status is miss (2'b01). This includes page numbers that share an index, and page numbers that differ from the tag only in bits [19:16].
- R6: The 12-bit page offset `req_vaddr[11:0]` appears unchanged in `rsp_paddr[11:0]` for every status, and the frame field `rsp_paddr[19:12]` is zero on a miss or page fault.
- R7: A response appears exactly one clock after the request: `rsp_valid` is high in the cycle after `req_valid` is high, and low in the cycle after `req_valid` is low.
- R8: In a cycle with no request, `rsp_paddr` and `rsp_status` keep their previous values.
- R9: A write to the index being looked up in the same cycle does not change that lookup, which sees the old entry. The next lookup sees the written entry.
- R10: A write replaces tag, frame and resident flag of the entry at `wr_index` together. A write with `wr_valid` low therefore invalidates the entry, and a later lookup of its tag faults.
- R11: The status value 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 20 | Physical address {frame, offset} |
| rsp_status | output | 2 | 00 hit, 01 miss, 10 page fault |
| wr_en | input | 1 | Table write strobe |
| wr_index | input | 8 | Entry to write |
| wr_tag | input | 20 | Virtual page number stored as tag |
| wr_frame | input | 8 | Frame number stored in the entry |
| wr_valid | input | 1 | Resident flag stored in the entry |

## Verification
The hardest case to reach from the ports is an aliased page number. It lands on the same index as a resident entry and matches its low 16 bits, but differs above bit 15. It must report a miss, not a false hit. The stimulus picks page numbers 0x12345 and 0x92345, which share index 0x66, and also 0x00066, which hashes to the same slot. It then drives a write and a lookup to the same slot in one cycle and checks that the old contents are returned before the new ones become visible.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic [1:0] {
        ST_HIT   = 2'b00,
        ST_MISS  = 2'b01,
        ST_FAULT = 2'b10
    } status_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 8,
    parameter int FOLDS = 2
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] part [FOLDS];

    for (genvar g = 0; g < FOLDS; g++) begin : g_fold
        assign part[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < FOLDS; i++) idx = idx ^ part[i];
    end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
    parameter int IDX_W   = 8,
    parameter int TAG_W   = 20,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_res,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_res
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [FRAME_W-1:0] frame;
        logic               res;
    } entry_t;

    entry_t tbl_d [DEPTH];
    entry_t tbl_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) tbl_d[i] = tbl_q[i];
        if (wr_en) tbl_d[wr_idx] = '{tag: wr_tag, frame: wr_frame, res: wr_res};
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) tbl_q[i] <= '0;
            else        tbl_q[i] <= tbl_d[i];
        end
    end

    assign rd_tag   = tbl_q[rd_idx].tag;
    assign rd_frame = tbl_q[rd_idx].frame;
    assign rd_res   = tbl_q[rd_idx].res;

    // R10
    entry_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)].tag == $past(wr_tag)) &&
                  (tbl_q[$past(wr_idx)].frame == $past(wr_frame)) &&
                  (tbl_q[$past(wr_idx)].res == $past(wr_res)));
endmodule

// File: rtl/ipt_compare.sv
module ipt_compare
    import ipt_pkg::*;
#(
    parameter int TAG_W   = 20,
    parameter int FRAME_W = 8
) (
    input  logic [TAG_W-1:0]   vpn,
    input  logic [TAG_W-1:0]   tag,
    input  logic [FRAME_W-1:0] frame,
    input  logic               res,
    output status_e            status,
    output logic [FRAME_W-1:0] frame_out
);
    logic match;
    assign match = (tag == vpn);

    always_comb begin
        frame_out = '0;
        if (!match) begin
            status = ST_MISS;
        end else if (!res) begin
            status = ST_FAULT;
        end else begin
            status    = ST_HIT;
            frame_out = frame;
        end
    end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
    import ipt_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PAGE_W  = 12,
    parameter int IDX_W   = 8,
    parameter int FRAME_W = 8,
    parameter int FOLDS   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_vaddr,
    output logic                      rsp_valid,
    output logic [FRAME_W+PAGE_W-1:0] rsp_paddr,
    output logic [1:0]                rsp_status,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_index,
    input  logic [VA_W-PAGE_W-1:0]    wr_tag,
    input  logic [FRAME_W-1:0]        wr_frame,
    input  logic                      wr_valid
);
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PA_W  = FRAME_W + PAGE_W;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        status_e         status;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [VPN_W-1:0]   vpn;
    logic [PAGE_W-1:0]  offset;
    logic [IDX_W-1:0]   idx;
    logic [VPN_W-1:0]   ent_tag;
    logic [FRAME_W-1:0] ent_frame;
    logic               ent_res;
    status_e            cmp_status;
    logic [FRAME_W-1:0] cmp_frame;

    assign vpn    = req_vaddr[VA_W-1:PAGE_W];
    assign offset = req_vaddr[PAGE_W-1:0];

    ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W), .FOLDS(FOLDS)) u_hash (
        .vpn (vpn),
        .idx (idx)
    );

    ipt_table #(.IDX_W(IDX_W), .TAG_W(VPN_W), .FRAME_W(FRAME_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_tag   (ent_tag),
        .rd_frame (ent_frame),
        .rd_res   (ent_res),
        .wr_en    (wr_en),
        .wr_idx   (wr_index),
        .wr_tag   (wr_tag),
        .wr_frame (wr_frame),
        .wr_res   (wr_valid)
    );

    ipt_compare #(.TAG_W(VPN_W), .FRAME_W(FRAME_W)) u_cmp (
        .vpn       (vpn),
        .tag       (ent_tag),
        .frame     (ent_frame),
        .res       (ent_res),
        .status    (cmp_status),
        .frame_out (cmp_frame)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.paddr  = {cmp_frame, offset};
            rsp_d.status = cmp_status;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '{valid: 1'b0, paddr: '0, status: ST_MISS};
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_paddr  = rsp_q.paddr;
    assign rsp_status = rsp_q.status;

    // R7
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R7
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R6
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0]));
    // R6
    nohit_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'b00) |-> rsp_paddr[PA_W-1:PAGE_W] == '0);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_paddr) && $stable(rsp_status));
    // R11
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status != 2'b11);
endmodule

// File: tb/ipt_lookup_bench.sv
module ipt_lookup_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [19:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_index = '0;
    logic [19:0] wr_tag = '0;
    logic [7:0]  wr_frame = '0;
    logic        wr_valid = 1'b0;

    int checks = 0;
    int fails  = 0;

    localparam logic [1:0] HIT = 2'b00, MISS = 2'b01, FAULT = 2'b10;

    always #2 clk = ~clk;

    ipt_lookup u_ipt_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
        .wr_en(wr_en), .wr_index(wr_index), .wr_tag(wr_tag),
        .wr_frame(wr_frame), .wr_valid(wr_valid)
    );

    function automatic logic [7:0] hidx(input logic [19:0] v);
        return v[7:0] ^ v[15:8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input string req, input logic [19:0] vpn, input logic [11:0] off,
                          input logic [1:0] st, input logic [7:0] frame);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check({req, " R7 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        check({req, " status"}, {30'b0, rsp_status}, {30'b0, st});
        check({req, " R6 paddr"}, {12'b0, rsp_paddr}, {12'b0, frame, off});
    endtask

    task automatic write(input logic [7:0] idx, input logic [19:0] tag,
                         input logic [7:0] frame, input logic res);
        wr_en = 1'b1; wr_index = idx; wr_tag = tag; wr_frame = frame; wr_valid = res;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        lookup("R1 vpn0 fault", 20'h00000, 12'hABC, FAULT, 8'h00);
        lookup("R1 R5 vpn101 miss", 20'h00101, 12'h001, MISS, 8'h00);
    endtask

    task automatic t_hit;
        write(hidx(20'h12345), 20'h12345, 8'h9A, 1'b1);
        lookup("R2 R3 hit", 20'h12345, 12'h678, HIT, 8'h9A);
        lookup("R3 R6 hit offset fff", 20'h12345, 12'hFFF, HIT, 8'h9A);
    endtask

    task automatic t_alias;
        check("R2 alias shares index", {24'b0, hidx(20'h92345)}, 32'h66);
        lookup("R5 upper bits alias", 20'h92345, 12'h010, MISS, 8'h00);
        lookup("R5 collision 0x00066", 20'h00066, 12'h020, MISS, 8'h00);
        lookup("R5 other index", 20'h13244, 12'h030, MISS, 8'h00);
    endtask

    task automatic t_invalidate;
        write(8'h66, 20'h12345, 8'h9A, 1'b0);
        lookup("R4 R10 invalidated fault", 20'h12345, 12'h444, FAULT, 8'h00);
    endtask

    task automatic t_same_cycle;
        wr_en = 1'b1; wr_index = 8'h66; wr_tag = 20'h12345; wr_frame = 8'h3C; wr_valid = 1'b1;
        lookup("R9 same-cycle sees old", 20'h12345, 12'h555, FAULT, 8'h00);
        wr_en = 1'b0;
        lookup("R9 next sees new", 20'h12345, 12'h556, HIT, 8'h3C);
    endtask

    task automatic t_idle;
        logic [19:0] pa;
        logic [1:0]  st;
        pa = rsp_paddr; st = rsp_status;
        req_vaddr = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 idle rsp_valid low", {31'b0, rsp_valid}, 32'd0);
        check("R8 paddr held", {12'b0, rsp_paddr}, {12'b0, pa});
        check("R8 status held", {30'b0, rsp_status}, {30'b0, st});
    endtask

    task automatic t_back_to_back;
        write(8'h10, 20'h00010, 8'h01, 1'b1);
        write(8'h20, 20'hA0020, 8'hF0, 1'b1);
        req_valid = 1'b1; req_vaddr = {20'h00010, 12'h111};
        @(posedge clk); @(negedge clk);
        check("R3 b2b first", {12'b0, rsp_paddr}, {12'b0, 8'h01, 12'h111});
        req_vaddr = {20'hA0020, 12'h222};
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check("R3 b2b second", {12'b0, rsp_paddr}, {12'b0, 8'hF0, 12'h222});
        check("R11 status hit", {30'b0, rsp_status}, {30'b0, HIT});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_hit;
        t_alias;
        t_invalidate;
        t_same_cycle;
        t_idle;
        t_back_to_back;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule